// File: doc/BRIEF.md
# Bit-Serial NAND Ring Engine

This block does all of its computing with one two-input NAND gate that is reused on every clock. All state and all intermediate wire values are kept in a long ring of flip-flops. The ring turns by one position on every clock edge, with no way to stall it. On each edge the bit leaving the head of the ring can be loaded into a left operand register, a right operand register, or both. The bit entering the tail is one of three things: the head bit passed back unchanged, an external data bit, or the NAND of the two operand registers.

The block has no program store and no sequencer. An outside host drives the operand load enables, the write enable and the write-source select on every cycle, and times them against the ring's rotation. A ring slot is addressed only by when it passes the head. A bit written on some edge can be read back exactly `RING_DEPTH` edges later. The current NAND value is also driven on an output so the host can see results. Any logic function can be built from a fixed sequence of these steps.

Top module: `nand_ring_engine`

## Requirements
- R1: The ring advances one position on every clock edge. A bit written into the tail on edge k is the head bit loaded by a capture on edge k+RING_DEPTH. The slots on either side of it are unaffected.
- R2: When `wr_en_i` is 0, the head bit passes into the tail unchanged, so a stored bit reappears at the head once every RING_DEPTH edges for as long as it is not overwritten.
- R3: `cap_left_i`=1 loads the head bit into the left operand and `cap_right_i`=1 loads it into the right operand. When both are 1 on the same edge, both operands take the same head bit.
- R4: An operand register whose load enable is 0 keeps its value, whatever bits pass the head.
- R5: `nand_o` is the NAND of the left and right operand registers, updated in the same cycle they change.
- R6: With `wr_en_i`=1, `wr_sel_i`=0 writes `ext_bit_i` into the tail and `wr_sel_i`=1 writes the NAND result. With `wr_en_i`=0, neither `ext_bit_i` nor `wr_sel_i` has any effect on the ring.
- R7: When a capture and a write occur on the same edge, the operands take the outgoing head bit. The written NAND value is the one formed from the operands as they stood before that edge.
- R8: Driving `rst_n` low clears both operands at once, so `nand_o` becomes 1. It also clears every ring slot to 0. This holds whether reset is applied at start-up or in the middle of operation.
- R9: Take a sequence that loads the left operand from slot a and the right from slot b, then writes NAND to slot c. A rotation later it loads both operands from slot c and writes NAND to slot d. Slot d then holds a AND b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the ring advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the host |
| cap_left_i | input | 1 | Load the head bit into the left operand |
| cap_right_i | input | 1 | Load the head bit into the right operand |
| wr_en_i | input | 1 | Replace the recirculated bit at the tail |
| wr_sel_i | input | 1 | Write source: 0 = `ext_bit_i`, 1 = NAND result |
| ext_bit_i | input | 1 | External data bit for writes |
| nand_o | output | 1 | NAND of the two operand registers |

## Verification
A bound checker checks the per-edge rules on every cycle. It checks operand load and hold, what enters the tail under each write setting, and which NAND value is written when a capture and a write occur on the same edge. It cannot see the full ring delay or the contents of slots that are out of view. Only the bench scenarios can show those. They show the exact RING_DEPTH latency and that neighbouring slots are left alone. They show persistence over many rotations, the complete AND sequence for all four input pairs, and that a reset in mid-run clears every slot.

// File: rtl/nre_pkg.sv
package nre_pkg;

  // Source of the bit written into the ring tail when a write is enabled.
  typedef enum logic {
    SRC_EXT  = 1'b0,
    SRC_NAND = 1'b1
  } wr_src_e;

  localparam int unsigned NUM_OPND = 2;

endpackage

// File: rtl/nre_ring.sv
// Circulating storage: shifts one place toward the head on every edge.
module nre_ring #(
  parameter int unsigned DEPTH = 880
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tail_d_i,
  output logic head_o,
  output logic tail_q_o
);

  localparam int unsigned HEAD_IDX = 0;
  localparam int unsigned TAIL_IDX = DEPTH - 1;

  logic [DEPTH-1:0] ring_q;
  logic [DEPTH-1:0] ring_d;

  always_comb begin
    ring_d = {tail_d_i, ring_q[TAIL_IDX:HEAD_IDX+1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= '0;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign head_o   = ring_q[HEAD_IDX];
  assign tail_q_o = ring_q[TAIL_IDX];

endmodule

// File: rtl/nre_operand_reg.sv
// One operand bit with an explicit load enable.
module nre_operand_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);

  logic opnd_q;
  logic opnd_d;

  always_comb begin
    opnd_d = opnd_q;
    if (en_i) begin
      opnd_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= 1'b0;
    end else begin
      opnd_q <= opnd_d;
    end
  end

  assign q_o = opnd_q;

endmodule

// File: rtl/nre_nand_path.sv
// The shared NAND gate and the tail write-back selection.
module nre_nand_path
  import nre_pkg::*;
(
  input  logic    left_i,
  input  logic    right_i,
  input  logic    head_i,
  input  logic    ext_i,
  input  logic    wr_en_i,
  input  wr_src_e src_i,
  output logic    nand_o,
  output logic    tail_d_o
);

  logic nand_val;

  always_comb begin
    nand_val = ~(left_i & right_i);
    tail_d_o = head_i;
    if (wr_en_i) begin
      unique case (src_i)
        SRC_EXT:  tail_d_o = ext_i;
        SRC_NAND: tail_d_o = nand_val;
        default:  tail_d_o = head_i;
      endcase
    end
  end

  assign nand_o = nand_val;

endmodule

// File: rtl/nand_ring_engine.sv
module nand_ring_engine
  import nre_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 880
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_left_i,
  input  logic cap_right_i,
  input  logic wr_en_i,
  input  logic wr_sel_i,
  input  logic ext_bit_i,
  output logic nand_o
);

  localparam int unsigned LEFT_IDX  = 0;
  localparam int unsigned RIGHT_IDX = 1;

  logic                head_bit;
  logic                tail_bit;
  logic                tail_d;
  logic [NUM_OPND-1:0] opnd_en;
  logic [NUM_OPND-1:0] opnd_q;
  logic                left_q;
  logic                right_q;
  wr_src_e             wr_src;

  assign opnd_en[LEFT_IDX]  = cap_left_i;
  assign opnd_en[RIGHT_IDX] = cap_right_i;
  assign wr_src             = wr_src_e'(wr_sel_i);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    nre_operand_reg u_opnd (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (opnd_en[g]),
      .d_i   (head_bit),
      .q_o   (opnd_q[g])
    );
  end

  assign left_q  = opnd_q[LEFT_IDX];
  assign right_q = opnd_q[RIGHT_IDX];

  nre_nand_path u_path (
    .left_i   (left_q),
    .right_i  (right_q),
    .head_i   (head_bit),
    .ext_i    (ext_bit_i),
    .wr_en_i  (wr_en_i),
    .src_i    (wr_src),
    .nand_o   (nand_o),
    .tail_d_o (tail_d)
  );

  nre_ring #(
    .DEPTH (RING_DEPTH)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .tail_d_i (tail_d),
    .head_o   (head_bit),
    .tail_q_o (tail_bit)
  );

endmodule

// File: rtl/nre_checker.sv
module nre_checker (
  input logic clk,
  input logic rst_n,
  input logic cap_left_i,
  input logic cap_right_i,
  input logic wr_en_i,
  input logic wr_sel_i,
  input logic ext_bit_i,
  input logic nand_o,
  input logic head_bit,
  input logic tail_bit,
  input logic left_q,
  input logic right_q
);

  a_r3_left_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_left_i |=> (left_q == $past(head_bit)));

  a_r3_right_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_right_i |=> (right_q == $past(head_bit)));

  a_r4_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_left_i |=> $stable(left_q));

  a_r4_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_right_i |=> $stable(right_q));

  a_r2_recirculate: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (tail_bit == $past(head_bit)));

  a_r6_ext_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=> (tail_bit == $past(ext_bit_i)));

  // R7: written NAND value comes from the operands before the edge.
  a_r7_nand_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i) |=> (tail_bit == $past(nand_o)));

endmodule

bind nand_ring_engine nre_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_left_i  (cap_left_i),
  .cap_right_i (cap_right_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .ext_bit_i   (ext_bit_i),
  .nand_o      (nand_o),
  .head_bit    (head_bit),
  .tail_bit    (tail_bit),
  .left_q      (left_q),
  .right_q     (right_q)
);

// File: tb/tb_nand_ring_engine.sv
`timescale 1ns/1ps
module tb_nand_ring_engine;

  localparam int unsigned D = 880;

  logic clk;
  logic rst_n;
  logic cap_left_i;
  logic cap_right_i;
  logic wr_en_i;
  logic wr_sel_i;
  logic ext_bit_i;
  logic nand_o;

  int checks;
  int errors;
  int edges;
  bit done;

  nand_ring_engine #(.RING_DEPTH(D)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_left_i  (cap_left_i),
    .cap_right_i (cap_right_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .ext_bit_i   (ext_bit_i),
    .nand_o      (nand_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One clock edge with the given controls; returns at the following falling edge.
  task automatic tick(input logic cl, input logic cr, input logic we,
                      input logic ws, input logic eb);
    cap_left_i  = cl;
    cap_right_i = cr;
    wr_en_i     = we;
    wr_sel_i    = ws;
    ext_bit_i   = eb;
    @(posedge clk);
    edges++;
    @(negedge clk);
    cap_left_i  = 1'b0;
    cap_right_i = 1'b0;
    wr_en_i     = 1'b0;
    wr_sel_i    = 1'b0;
    ext_bit_i   = 1'b0;
  endtask

  // Idle until the next edge falls on ring slot s.
  task automatic run_to(input int s);
    while (((edges + 1) % D) != s) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic write_ext(input int s, input logic b);
    run_to(s);
    tick(1'b0, 1'b0, 1'b1, 1'b0, b);
  endtask

  // Loads both operands from slot s and returns the stored bit (nand_o = ~bit).
  task automatic peek(input int s, output logic b);
    run_to(s);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    b = ~nand_o;
  endtask

  task automatic scan_all_zero(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < int'(D); i++) begin
      tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      if (nand_o !== 1'b1) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: actual %0d nonzero slots expected 0", req, bad);
    end
  endtask

  task automatic t_reset;
    check_bit("R8 operands clear after reset", nand_o, 1'b1);
    scan_all_zero("R8 ring clear after reset");
  endtask

  task automatic t_delay_and_persist;
    logic b;
    write_ext(100, 1'b1);
    run_to(99);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R1 slot before written slot", nand_o, 1'b1);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R1 written bit after RING_DEPTH edges", nand_o, 1'b0);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R1 slot after written slot", nand_o, 1'b1);
    peek(100, b);
    check_bit("R2 bit kept second rotation", b, 1'b1);
    peek(100, b);
    check_bit("R2 bit kept third rotation", b, 1'b1);
  endtask

  task automatic t_capture_hold;
    write_ext(200, 1'b1);
    run_to(200);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_to(100);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R3 left and right loaded separately", nand_o, 1'b0);
    for (int i = 0; i < 50; i++) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_bit("R4 operands held while idle", nand_o, 1'b0);
    run_to(210);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R3 right loaded with 0", nand_o, 1'b1);
    run_to(200);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R4 left held while right reloads", nand_o, 1'b0);
  endtask

  task automatic t_write_sources;
    logic b;
    run_to(210);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R5 nand of 1 and 0", nand_o, 1'b1);
    run_to(300);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_to(200);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R5 nand of 1 and 1", nand_o, 1'b0);
    run_to(310);
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_to(320);
    tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    peek(300, b);
    check_bit("R6 nand source wrote 1", b, 1'b1);
    peek(310, b);
    check_bit("R6 nand source wrote 0 ignoring ext", b, 1'b0);
    peek(320, b);
    check_bit("R6 ext ignored without write enable", b, 1'b0);
    peek(321, b);
    check_bit("R6 select ignored without write enable", b, 1'b0);
  endtask

  task automatic t_same_edge;
    logic b;
    write_ext(400, 1'b1);
    run_to(200);
    tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_to(210);
    tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_to(400);
    tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    check_bit("R7 operands take outgoing head", nand_o, 1'b0);
    peek(400, b);
    check_bit("R7 written nand is pre-edge value", b, 1'b1);
    run_to(200);
    tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check_bit("R7 capture with ext write sees old bit", nand_o, 1'b0);
    peek(200, b);
    check_bit("R7 ext write replaced captured slot", b, 1'b0);
  endtask

  task automatic t_and;
    logic b;
    for (int k = 0; k < 4; k++) begin
      logic a_v;
      logic b_v;
      a_v = logic'(k[1]);
      b_v = logic'(k[0]);
      write_ext(500, a_v);
      write_ext(510, b_v);
      run_to(500);
      tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      run_to(510);
      tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      run_to(520);
      tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      run_to(520);
      tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      run_to(530);
      tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      peek(530, b);
      check_bit($sformatf("R9 AND of %b and %b", a_v, b_v), b, a_v & b_v);
    end
  endtask

  task automatic t_midrun_reset;
    write_ext(600, 1'b1);
    run_to(100);
    tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check_bit("R8 operands set before reset", nand_o, 1'b0);
    #2;
    rst_n = 1'b0;
    #1;
    check_bit("R8 async reset clears operands", nand_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    scan_all_zero("R8 ring clear after mid-run reset");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    edges  = 0;
    done   = 1'b0;
    rst_n       = 1'b0;
    cap_left_i  = 1'b0;
    cap_right_i = 1'b0;
    wr_en_i     = 1'b0;
    wr_sel_i    = 1'b0;
    ext_bit_i   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_delay_and_persist();
    t_capture_hold();
    t_write_sources();
    t_same_edge();
    t_and();
    t_midrun_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule